// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block turns one parallel video pixel (8-bit red, green and blue plus horizontal sync, vertical sync and data-enable) into up to four serial data lanes and one companion clock lane for a low-voltage differential flat-panel link. Every pixel period spans seven fast-clock cycles. In each of those cycles, every lane presents one bit, called a slot. The fast clock runs at seven times the pixel rate. An internal modulo-7 counter marks the one cycle per period in which a new pixel is taken.

Three bit layouts are available. The first is an 18-bit layout on three lanes. The other two are 24-bit layouts on four lanes, which differ in where the two extra bits of each color go. A mirror flag makes the data lanes send their seven slots last-to-first. The layout selector and the mirror flag are static settings. A change to them takes effect only at a pixel boundary whose pixel carries no active video. The differential buffers and the fast-clock source lie outside this block.

The pixel input is a valid/ready stream. The block raises `pix_ready` for exactly one cycle in every seven. A pixel moves only in a cycle where `pix_valid` and `pix_ready` are both high. The source must hold its pixel until then. If `pix_valid` is low in the ready cycle, the block sends a blank pixel in that period, with every color and control bit zero. It never stalls the clock lane.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: A synchronous reset clears every lane output, the clock lane and `pix_ready` to 0 and restarts the slot counter. `pix_ready` first rises in the 7th cycle after reset is released, that is, after 6 rising edges.
- R2: With `cfg_mode` set to 0 (or to the spare code 3), the 18-bit layout is used. It takes the six most significant bits of each channel, so bit k of a six-bit field is channel bit k+2. The slots 0..6 carry:
  - lane 0: G0, R5, R4, R3, R2, R1, R0
  - lane 1: B1, B0, G5, G4, G3, G2, G1
  - lane 2: DE, VS, HS, B5, B4, B3, B2
  - lane 3: 0 in every slot.
- R3: With `cfg_mode` set to 1, the first 24-bit layout is used. The slots 0..6 carry:
  - lane 0: g[2], r[7], r[6], r[5], r[4], r[3], r[2]
  - lane 1: b[3], b[2], g[7], g[6], g[5], g[4], g[3]
  - lane 2: DE, VS, HS, b[7], b[6], b[5], b[4]
  - lane 3: 0, b[1], b[0], g[1], g[0], r[1], r[0].
- R4: With `cfg_mode` set to 2, the second 24-bit layout is used. Lanes 0..2 follow the R2 arrangement, but on channel bits [5:0]. Lane 3 carries 0, b[7], b[6], g[7], g[6], r[7], r[6] in slots 0..6.
- R5: The control slots map as follows: HS takes lane 2 slot 2, VS takes lane 2 slot 1, DE takes lane 2 slot 0, and lane 3 slot 0 is always 0.
- R6: With the mirror flag in effect, each data lane sends slot 6 first and slot 0 last. The contents of the slots do not change.
- R7: The clock lane sends 1,1,0,0,0,1,1 over slots 0..6 of every pixel period. It is aligned to slot 0 of the data lanes, and the mirror flag does not affect it.
- R8: `pix_ready` is high one cycle in every seven. A pixel accepted at a rising edge shows its first transmitted slot on all lanes and on the clock lane in the cycle right after that edge. Each following edge advances one slot.
- R9: The layout and mirror settings that are in force are updated only at reset or at a ready cycle whose pixel is not an accepted pixel with DE high. The pixel of that ready cycle already uses the new settings. At a ready cycle that accepts a pixel with DE high, the settings already in force stay in force.
- R10: A ready cycle with `pix_valid` low transmits a pixel whose bits are all 0 on every data lane. The clock lane keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (7x pixel) clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Layout select: 0 = 18-bit, 1 = 24-bit first, 2 = 24-bit second, 3 = 18-bit |
| cfg_mirror | input | 1 | Send data slots 6..0 instead of 0..6 |
| pix_valid | input | 1 | Source offers a pixel |
| pix_ready | output | 1 | Block takes a pixel this cycle |
| pix_r | input | 8 | Red channel |
| pix_g | input | 8 | Green channel |
| pix_b | input | 8 | Blue channel |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable (active video) |
| data_lane | output | 4 | Serial data lanes, bit n is lane n |
| clk_lane | output | 1 | Serial companion clock lane |

## Verification
Some properties are checked on every cycle:
- the one-in-seven spacing of `pix_ready`;
- the high clock-lane slot directly after each load, and its low slot three cycles later;
- all-zero data lanes after a ready cycle with no valid pixel;
- the frozen settings after an accepted active-video pixel.

Only the bench's scenarios can show whether every bit reaches its proper lane and slot in each of the three layouts, under mirroring. The same holds for the point at which a layout change mid-line takes effect, and for a reset in mid-period.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  parameter int SLOTS = 7;
  parameter int LANES = 4;
  parameter int CH_W  = 8;
  localparam int FIELD_W = CH_W - 2;

  typedef enum logic [1:0] {
    MAP_18  = 2'd0,
    MAP_24A = 2'd1,
    MAP_24B = 2'd2,
    MAP_RSV = 2'd3
  } map_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
    logic            hs;
    logic            vs;
    logic            de;
  } pixel_t;

  typedef struct packed {
    map_e mode;
    logic mirror;
  } cfg_t;

  typedef logic [SLOTS-1:0] slot_word_t;

  // bit s = slot s
  localparam slot_word_t CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/lvds_slot_counter.sv
module lvds_slot_counter
  import lvds_ser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic load
);
  localparam int CW = $clog2(SLOTS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign load = (cnt == LAST);
endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
  import lvds_ser_pkg::*;
(
  input  pixel_t                        px,
  input  map_e                          mode,
  output logic [LANES-1:0][SLOTS-1:0]   words
);
  logic [FIELD_W-1:0] r6, g6, b6;
  logic               low_field;

  always_comb begin
    low_field = (mode == MAP_24B);
    r6 = low_field ? px.r[FIELD_W-1:0] : px.r[CH_W-1:2];
    g6 = low_field ? px.g[FIELD_W-1:0] : px.g[CH_W-1:2];
    b6 = low_field ? px.b[FIELD_W-1:0] : px.b[CH_W-1:2];

    words = '0;
    // packed as {slot6 .. slot0}
    words[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
    words[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
    words[2] = {b6[2], b6[3], b6[4], b6[5], px.hs, px.vs, px.de};
    case (mode)
      MAP_24A: words[3] = {px.r[0], px.r[1], px.g[0], px.g[1],
                           px.b[0], px.b[1], 1'b0};
      MAP_24B: words[3] = {px.r[6], px.r[7], px.g[6], px.g[7],
                           px.b[6], px.b[7], 1'b0};
      default: words[3] = '0;
    endcase
  end
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter
  import lvds_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       mirror,
  input  slot_word_t word,
  output logic       ser
);
  slot_word_t sr, rev;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) rev[i] = word[SLOTS-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (load) sr <= mirror ? rev : word;
    else           sr <= sr >> 1;
  end

  assign ser = sr[0];
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_mirror,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [CH_W-1:0]  pix_r,
  input  logic [CH_W-1:0]  pix_g,
  input  logic [CH_W-1:0]  pix_b,
  input  logic             pix_hs,
  input  logic             pix_vs,
  input  logic             pix_de,
  output logic [LANES-1:0] data_lane,
  output logic             clk_lane
);
  logic                      load;
  logic                      accept, hold;
  pixel_t                    px;
  cfg_t                      cfg_in, cfg_q, cfg_eff;
  logic [LANES-1:0][SLOTS-1:0] words;

  lvds_slot_counter u_cnt (.clk(clk), .rst(rst), .load(load));

  assign pix_ready = load & ~rst;
  assign accept    = pix_ready & pix_valid;
  assign hold      = accept & pix_de;
  assign px        = accept ? pixel_t'{r: pix_r, g: pix_g, b: pix_b,
                                       hs: pix_hs, vs: pix_vs, de: pix_de}
                            : '0;
  assign cfg_in    = cfg_t'{mode: map_e'(cfg_mode), mirror: cfg_mirror};
  assign cfg_eff   = hold ? cfg_q : cfg_in;

  always_ff @(posedge clk) begin
    if (rst)            cfg_q <= cfg_in;
    else if (pix_ready) cfg_q <= cfg_eff;
  end

  lvds_lane_mapper u_map (.px(px), .mode(cfg_eff.mode), .words(words));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lvds_lane_shifter u_sh (
      .clk(clk), .rst(rst), .load(pix_ready), .mirror(cfg_eff.mirror),
      .word(words[l]), .ser(data_lane[l])
    );
  end

  lvds_lane_shifter u_clk_sh (
    .clk(clk), .rst(rst), .load(pix_ready), .mirror(1'b0),
    .word(CLK_PATTERN), .ser(clk_lane)
  );
endmodule

// File: rtl/lvds_ser_checker.sv
module lvds_ser_checker
  import lvds_ser_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic             pix_de,
  input logic [LANES-1:0] data_lane,
  input logic             clk_lane,
  input logic [2:0]       cfg_state
);
  localparam int GW = $clog2(SLOTS + 1);
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || pix_ready) gap <= '0;
    else if (gap != GW'(SLOTS)) gap <= gap + 1'b1;
  end

  p_ready_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> (gap == GW'(SLOTS - 1)));

  p_ready_single_r8: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> !pix_ready);

  p_clk_first_slot_r7: assert property (@(posedge clk) disable iff (rst)
    pix_ready |=> clk_lane);

  p_clk_mid_slot_r7: assert property (@(posedge clk) disable iff (rst)
    $past(pix_ready, 3) |-> !clk_lane);

  p_blank_pixel_r10: assert property (@(posedge clk) disable iff (rst)
    (pix_ready && !pix_valid) |=> (data_lane == '0));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (pix_ready && pix_valid && pix_de) |=> $stable(cfg_state));
endmodule

bind lvds_pixel_serializer lvds_ser_checker u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_de(pix_de), .data_lane(data_lane), .clk_lane(clk_lane),
  .cfg_state(cfg_q)
);

// File: tb/tb_lvds_pixel_serializer.sv
module tb_lvds_pixel_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_mirror = 1'b0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic       pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
  logic [3:0] data_lane;
  logic       clk_lane;

  always #2 clk = ~clk;

  lvds_pixel_serializer dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_mirror(cfg_mirror),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
    .data_lane(data_lane), .clk_lane(clk_lane)
  );

  // codes: 0..7 red bit, 8..15 green, 16..23 blue, 24 HS, 25 VS, 26 DE, 27 zero
  localparam int T18[28] = '{10,7,6,5,4,3,2,  19,18,15,14,13,12,11,
                             26,25,24,23,22,21,20,  27,27,27,27,27,27,27};
  localparam int T24A[28] = '{10,7,6,5,4,3,2,  19,18,15,14,13,12,11,
                              26,25,24,23,22,21,20,  27,17,16,9,8,1,0};
  localparam int T24B[28] = '{8,5,4,3,2,1,0,  17,16,13,12,11,10,9,
                              26,25,24,21,20,19,18,  27,23,22,15,14,7,6};
  localparam bit [6:0] CLK_PAT = 7'b1100011;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  string ph_tag = "R1";

  // behavioural reference
  int  m_cnt = 0, m_k = 0, h_mode = 0;
  bit  h_mir = 0, m_mir = 0, m_active = 0;
  bit  m_slots[4][7];

  function automatic bit pick(int code, bit [7:0] r, g, b, bit hs, vs, de);
    if (code < 8)       return r[code];
    else if (code < 16) return g[code-8];
    else if (code < 24) return b[code-16];
    else if (code == 24) return hs;
    else if (code == 25) return vs;
    else if (code == 26) return de;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_k = 0; m_active = 0;
      h_mode = int'(cfg_mode); h_mir = cfg_mirror;
    end else begin
      if (m_cnt == 6) begin
        bit [7:0] r, g, b;
        bit hs, vs, de;
        int md;
        r = pix_valid ? pix_r : 8'd0; g = pix_valid ? pix_g : 8'd0;
        b = pix_valid ? pix_b : 8'd0; hs = pix_valid & pix_hs;
        vs = pix_valid & pix_vs; de = pix_valid & pix_de;
        if (!(pix_valid && pix_de)) begin
          h_mode = int'(cfg_mode); h_mir = cfg_mirror;
        end
        md = h_mode; m_mir = h_mir;
        for (int l = 0; l < 4; l++)
          for (int s = 0; s < 7; s++) begin
            int c;
            c = (md == 1) ? T24A[l*7+s] : (md == 2) ? T24B[l*7+s] : T18[l*7+s];
            m_slots[l][s] = pick(c, r, g, b, hs, vs, de);
          end
        m_k = 0; m_active = 1;
      end else begin
        m_k = m_k + 1;
      end
      m_cnt = (m_cnt + 1) % 7;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit [3:0] el;
    bit ec;
    el = '0; ec = 1'b0;
    if (m_active && !rst) begin
      for (int l = 0; l < 4; l++) el[l] = m_slots[l][m_mir ? 6 - m_k : m_k];
      ec = CLK_PAT[m_k];
    end
    chk(rst ? "R1" : "R8", int'(pix_ready), int'(m_cnt == 6 && !rst));
    chk(rst ? "R1" : ph_tag, int'(data_lane), int'(el));
    chk(rst ? "R1" : "R7", int'(clk_lane), int'(ec));
  endtask

  // vmode: 0 never valid, 1 always, 2 random; de_hi forces DE high
  task automatic run(int cycles, int vmode, bit de_hi);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all();
      pix_r = 8'($urandom); pix_g = 8'($urandom); pix_b = 8'($urandom);
      pix_hs = 1'($urandom); pix_vs = 1'($urandom);
      pix_de = de_hi ? 1'b1 : 1'($urandom);
      pix_valid = (vmode == 1) ? 1'b1 : (vmode == 0) ? 1'b0 : 1'($urandom);
    end
  endtask

  task automatic set_cfg(int md, bit mir);
    @(negedge clk);
    compare_all();
    cfg_mode = 2'(md); cfg_mirror = mir;
    pix_de = 1'b0;
  endtask

  initial begin
    ph_tag = "R1";
    run(4, 0, 0);
    @(negedge clk); compare_all(); rst = 1'b0;
    ph_tag = "R2"; set_cfg(0, 0); run(84, 1, 0);
    ph_tag = "R3"; set_cfg(1, 0); run(84, 1, 0);
    ph_tag = "R5"; run(42, 2, 0);
    ph_tag = "R4"; set_cfg(2, 0); run(84, 1, 0);
    ph_tag = "R2"; set_cfg(3, 0); run(42, 1, 0);
    ph_tag = "R6"; set_cfg(2, 1); run(84, 1, 0);
    ph_tag = "R6"; set_cfg(1, 1); run(56, 1, 0);
    ph_tag = "R10"; run(42, 0, 0);
    ph_tag = "R9"; set_cfg(0, 0); run(21, 1, 1);
    cfg_mode = 2'd1; cfg_mirror = 1'b1;
    run(42, 1, 1);
    run(42, 1, 0);
    ph_tag = "R1"; run(3, 1, 0);
    @(negedge clk); compare_all(); rst = 1'b1;
    run(3, 1, 0);
    @(negedge clk); compare_all(); rst = 1'b0;
    ph_tag = "R8"; run(70, 2, 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule